// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

This block holds two up-counters of two bytes each. Each unit advances either on a machine-cycle tick or on falling edges seen on its external count pin. A per-unit gate bit can make counting depend on a gate pin. Each unit also has a run bit and an overflow flag. Software reaches all state through a small byte-wide register port: one control byte, one configuration byte and four counter bytes. The overflow flags go straight out as interrupt requests. An interrupt controller clears a flag by pulsing the matching acknowledge line.

Unit 0 can be split into two independent byte counters. Its low byte keeps all of unit 0's own controls. Its high byte counts machine cycles under unit 1's run bit and raises unit 1's flag. While unit 0 is split, unit 1 keeps counting under its gate condition alone, and it raises no flag. Putting unit 1 into split mode freezes it.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads 0 and both `ovf_flag` bits are 0.
- R2: Register map. Address 0x88 is control: bit 7 flag 1, bit 6 run 1, bit 5 flag 0, bit 4 run 0, and bits 3:0 read 0. Address 0x89 is configuration: bit 0 split, bit 1 event source and bit 2 gate for unit 0, and bits 4, 5 and 6 the same for unit 1, with bits 3 and 7 reading 0. Counter bytes sit at 0x8A (unit 0 low), 0x8B (unit 1 low), 0x8C (unit 0 high) and 0x8D (unit 1 high). `bus_rdata` shows the register selected by `bus_addr` as it stood at the previous clock edge.
- R3: In two-byte mode with the event source at 0, a unit whose run bit is 1 adds one on every cycle with `tick` high. With the run bit at 0 it holds.
- R4: When a unit's gate bit is 1, it counts only while its `gate_pin` is 1.
- R5: When the event source is 1, the pin is sampled only on tick cycles. A count happens on a tick whose sample is 0 when the sample from the previous tick was 1. Pin activity between ticks has no effect.
- R6: In two-byte mode a wrap from all ones to zero sets that unit's flag on the same clock edge.
- R7: `irq_ack[k]` clears flag k. A wrap in the same cycle wins over the acknowledge. A control-register write sets or clears both flags directly.
- R8: A write to a counter byte beats an increment in the same cycle. In two-byte mode a write to either byte cancels that unit's whole increment for that cycle.
- R9: With unit 0 split, its low byte counts under unit 0's run, gate and event controls. It wraps from 0xFF to 0x00 and sets flag 0, and the high byte does not change.
- R10: With unit 0 split, its high byte counts ticks while run 1 is set, ignores the gate and event settings, and sets flag 1 when it wraps.
- R11: With unit 1's split bit set, unit 1 holds its count whatever run 1 is.
- R12: While unit 0 is split and unit 1 is not, unit 1 counts whenever its gate condition allows, whatever run 1 is. Its wrap leaves flag 1 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable |
| evt_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | Gate inputs, one per unit |
| irq_ack | input | 2 | Flag clear pulses from the interrupt controller |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovf_flag | output | 2 | Overflow flags (bit 1 is unit 1) |

## Verification
The bench builds the block with its default byte width of 8 and the default addresses 0x88 to 0x8D. With 8-bit bytes, every wrap can be reached with a preload followed by one or two ticks. That covers the two-byte wrap, the low-byte and high-byte wraps in split mode, and a wrap that coincides with an acknowledge. The bench drives `tick` itself, so it places writes and acknowledges in exactly the cycle where they meet an increment.

// File: rtl/twin_timer_pkg.sv
`timescale 1ns/1ps
package twin_timer_pkg;
  // per-unit configuration fields; packing matches the configuration byte
  typedef struct packed {
    logic gate;
    logic evt;
    logic split;
  } unit_cfg_t;

  localparam int UNITS = 2;
  localparam int CFG_W = $bits(unit_cfg_t);
endpackage

// File: rtl/tmr_edge_sense.sv
`timescale 1ns/1ps
module tmr_edge_sense #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic samp_q;

    always_ff @(posedge clk) begin
      if (rst)       samp_q <= 1'b0;
      else if (tick) samp_q <= pin[i];
    end

    assign fall[i] = tick & samp_q & ~pin[i];

    // a counted edge leaves a low sample behind
    p_fall_low_r5: assert property (@(posedge clk) disable iff (rst)
      fall[i] |=> !samp_q);
  end
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                split,
  input  logic                step_lo,
  input  logic                step_hi,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] count,
  output logic                wrap_full,
  output logic                wrap_lo,
  output logic                wrap_hi
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] B_ONES = '1;
  localparam logic [CNT_W-1:0]  C_ONES = '1;

  logic [BYTE_W-1:0] lo_q, hi_q;
  assign count = {hi_q, lo_q};

  always_comb begin
    wrap_full = !split && step_lo && !wr_lo && !wr_hi && (count == C_ONES);
    wrap_lo   =  split && step_lo && !wr_lo && (lo_q == B_ONES);
    wrap_hi   =  split && step_hi && !wr_hi && (hi_q == B_ONES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (split) begin
      if (wr_lo)        lo_q <= wdata;
      else if (step_lo) lo_q <= lo_q + 1'b1;
      if (wr_hi)        hi_q <= wdata;
      else if (step_hi) hi_q <= hi_q + 1'b1;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end else if (step_lo) begin
      {hi_q, lo_q} <= count + 1'b1;
    end
  end

  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    !split && step_lo && !wr_lo && !wr_hi |=> count == $past(count) + 1'b1);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !split && !step_lo && !wr_lo && !wr_hi |=> $stable(count));
  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> lo_q == $past(wdata));
  p_lo_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    split && step_lo && !wr_lo && lo_q == B_ONES |=> lo_q == '0);
endmodule

// File: rtl/tmr_ctrl_regs.sv
`timescale 1ns/1ps
module tmr_ctrl_regs
  import twin_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h88,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h89,
  parameter logic [ADDR_W-1:0] LO0_ADDR = 'h8A,
  parameter logic [ADDR_W-1:0] LO1_ADDR = 'h8B,
  parameter logic [ADDR_W-1:0] HI0_ADDR = 'h8C,
  parameter logic [ADDR_W-1:0] HI1_ADDR = 'h8D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  input  logic [2*BYTE_W-1:0]     cnt0,
  input  logic [2*BYTE_W-1:0]     cnt1,
  input  logic [UNITS-1:0]        ovf_set,
  input  logic [UNITS-1:0]        irq_ack,
  output logic [UNITS-1:0]        run_q,
  output logic [UNITS-1:0]        flag_q,
  output unit_cfg_t [UNITS-1:0]   cfg_q,
  output logic [UNITS-1:0]        wr_lo,
  output logic [UNITS-1:0]        wr_hi
);
  logic wr_ctl, wr_cfg;
  logic [BYTE_W-1:0] rd_next;

  always_comb begin
    wr_ctl   = bus_wr && (bus_addr == CTL_ADDR);
    wr_cfg   = bus_wr && (bus_addr == CFG_ADDR);
    wr_lo[0] = bus_wr && (bus_addr == LO0_ADDR);
    wr_lo[1] = bus_wr && (bus_addr == LO1_ADDR);
    wr_hi[0] = bus_wr && (bus_addr == HI0_ADDR);
    wr_hi[1] = bus_wr && (bus_addr == HI1_ADDR);
  end

  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    localparam int RUN_BIT  = 4 + 2 * k;
    localparam int FLAG_BIT = 5 + 2 * k;
    localparam int CFG_LSB  = 4 * k;
    logic      run_r, flag_r;
    unit_cfg_t cfg_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        run_r <= 1'b0;
        cfg_r <= '0;
      end else begin
        if (wr_ctl) run_r <= bus_wdata[RUN_BIT];
        if (wr_cfg) cfg_r <= bus_wdata[CFG_LSB +: CFG_W];
      end
    end

    // priority: hardware wrap, then acknowledge, then software write
    always_ff @(posedge clk) begin
      if (rst)             flag_r <= 1'b0;
      else if (ovf_set[k]) flag_r <= 1'b1;
      else if (irq_ack[k]) flag_r <= 1'b0;
      else if (wr_ctl)     flag_r <= bus_wdata[FLAG_BIT];
    end

    assign run_q[k]  = run_r;
    assign flag_q[k] = flag_r;
    assign cfg_q[k]  = cfg_r;

    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
      ovf_set[k] |=> flag_r);
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
      irq_ack[k] && !ovf_set[k] |=> !flag_r);
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == CTL_ADDR) begin
      rd_next[7] = flag_q[1];
      rd_next[6] = run_q[1];
      rd_next[5] = flag_q[0];
      rd_next[4] = run_q[0];
    end else if (bus_addr == CFG_ADDR) begin
      rd_next[CFG_W-1:0]     = cfg_q[0];
      rd_next[4 +: CFG_W]    = cfg_q[1];
    end else if (bus_addr == LO0_ADDR) begin
      rd_next = cnt0[BYTE_W-1:0];
    end else if (bus_addr == LO1_ADDR) begin
      rd_next = cnt1[BYTE_W-1:0];
    end else if (bus_addr == HI0_ADDR) begin
      rd_next = cnt0[2*BYTE_W-1:BYTE_W];
    end else if (bus_addr == HI1_ADDR) begin
      rd_next = cnt1[2*BYTE_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/twin_timer.sv
`timescale 1ns/1ps
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 'h88,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h89,
  parameter logic [ADDR_W-1:0] LO0_ADDR = 'h8A,
  parameter logic [ADDR_W-1:0] LO1_ADDR = 'h8B,
  parameter logic [ADDR_W-1:0] HI0_ADDR = 'h8C,
  parameter logic [ADDR_W-1:0] HI1_ADDR = 'h8D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        evt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        irq_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [1:0]        ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  unit_cfg_t [UNITS-1:0] cfg_q;
  logic [UNITS-1:0] run_q, flag_q, wr_lo, wr_hi, ovf_set, fall;
  logic [UNITS-1:0] gate_ok, base_step, step_lo, step_hi, split_in;
  logic [UNITS-1:0] wrap_full, wrap_lo, wrap_hi;
  logic [CNT_W-1:0] cnt [UNITS];

  tmr_ctrl_regs #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .CTL_ADDR(CTL_ADDR), .CFG_ADDR(CFG_ADDR),
    .LO0_ADDR(LO0_ADDR), .LO1_ADDR(LO1_ADDR),
    .HI0_ADDR(HI0_ADDR), .HI1_ADDR(HI1_ADDR)
  ) i_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt0(cnt[0]), .cnt1(cnt[1]),
    .ovf_set(ovf_set), .irq_ack(irq_ack),
    .run_q(run_q), .flag_q(flag_q), .cfg_q(cfg_q),
    .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  tmr_edge_sense #(.N(UNITS)) i_edges (
    .clk(clk), .rst(rst), .tick(tick), .pin(evt_pin), .fall(fall)
  );

  // per-unit qualification of the count source
  for (genvar i = 0; i < UNITS; i++) begin : g_qual
    assign gate_ok[i]   = !cfg_q[i].gate || gate_pin[i];
    assign base_step[i] = cfg_q[i].evt ? fall[i] : tick;
  end

  always_comb begin
    split_in[0] = cfg_q[0].split;
    split_in[1] = 1'b0;                        // unit 1 never splits, it freezes
    step_lo[0]  = run_q[0] && gate_ok[0] && base_step[0];
    step_hi[0]  = run_q[1] && tick;            // borrowed run bit, ticks only
    step_lo[1]  = !cfg_q[1].split && gate_ok[1] && base_step[1]
                  && (cfg_q[0].split || run_q[1]);
    step_hi[1]  = 1'b0;
  end

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    tmr_unit #(.BYTE_W(BYTE_W)) i_unit (
      .clk(clk), .rst(rst),
      .split(split_in[i]), .step_lo(step_lo[i]), .step_hi(step_hi[i]),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
      .count(cnt[i]),
      .wrap_full(wrap_full[i]), .wrap_lo(wrap_lo[i]), .wrap_hi(wrap_hi[i])
    );
  end

  always_comb begin
    ovf_set[0] = wrap_full[0] || wrap_lo[0];
    ovf_set[1] = cfg_q[0].split ? wrap_hi[0]
                                : (wrap_full[1] || wrap_lo[1] || wrap_hi[1]);
  end

  assign ovf_flag = flag_q;

  p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_q[1].split && !wr_lo[1] && !wr_hi[1] |=> $stable(cnt[1]));
  p_hi_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_q[0].split && !run_q[1] && !wr_hi[0]
    |=> $stable(cnt[0][CNT_W-1:BYTE_W]));
  p_lo_only_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_q[0].split && !tick && !wr_hi[0]
    |=> $stable(cnt[0][CNT_W-1:BYTE_W]));
endmodule

// File: tb/test_twin_timer.sv
`timescale 1ns/1ps
module test_twin_timer;
  localparam logic [7:0] A_CTL = 8'h88, A_CFG = 8'h89;
  localparam logic [7:0] A_LO0 = 8'h8A, A_LO1 = 8'h8B;
  localparam logic [7:0] A_HI0 = 8'h8C, A_HI1 = 8'h8D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [1:0] evt_pin = '0, gate_pin = '0, irq_ack = '0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic [1:0] ovf_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  twin_timer i_twin_timer (
    .clk(clk), .rst(rst), .tick(tick), .evt_pin(evt_pin),
    .gate_pin(gate_pin), .irq_ack(irq_ack), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 flags", 16'(ovf_flag), 16'h0);
    rd(A_CTL, v); check("R1 ctl", 16'(v), 16'h0);
    rd(A_CFG, v); check("R1 cfg", 16'(v), 16'h0);
    rd(A_LO0, v); check("R1 lo0", 16'(v), 16'h0);
    rd(A_HI1, v); check("R1 hi1", 16'(v), 16'h0);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    wr(A_CFG, 8'hFF); rd(A_CFG, v); check("R2 cfg readback", 16'(v), 16'h77);
    wr(A_CTL, 8'hFF); rd(A_CTL, v); check("R2 ctl readback", 16'(v), 16'hF0);
    check("R7 software flag set", 16'(ovf_flag), 16'h3);
    wr(A_CTL, 8'h00); check("R7 software flag clear", 16'(ovf_flag), 16'h0);
    wr(A_LO1, 8'hA5); wr(A_HI1, 8'h5A);
    rd(A_LO1, v); check("R2 lo1", 16'(v), 16'hA5);
    rd(A_HI1, v); check("R2 hi1", 16'(v), 16'h5A);
    wr(A_CFG, 8'h00);
  endtask

  task automatic t_timer16;
    logic [7:0] v;
    wr(A_LO0, 8'h10); wr(A_HI0, 8'h00); wr(A_CTL, 8'h10);
    ticks(5);
    rd(A_LO0, v); check("R3 count ticks", 16'(v), 16'h15);
    wr(A_CTL, 8'h00);
    ticks(3);
    rd(A_LO0, v); check("R3 hold when stopped", 16'(v), 16'h15);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    wr(A_CFG, 8'h04); wr(A_LO0, 8'h00); wr(A_HI0, 8'h00); wr(A_CTL, 8'h10);
    gate_pin[0] = 1'b0;
    ticks(4);
    rd(A_LO0, v); check("R4 gate low blocks", 16'(v), 16'h0);
    gate_pin[0] = 1'b1;
    ticks(4);
    rd(A_LO0, v); check("R4 gate high counts", 16'(v), 16'h4);
    gate_pin[0] = 1'b0;
  endtask

  task automatic t_event;
    logic [7:0] v;
    logic [7:0] pat = 8'b0101_1001;
    wr(A_CFG, 8'h02); wr(A_LO0, 8'h00); wr(A_HI0, 8'h00); wr(A_CTL, 8'h10);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      tick = 1'b1;
      evt_pin[0] = pat[k];
    end
    @(negedge clk);
    tick = 1'b0;
    rd(A_LO0, v); check("R5 falling edges counted", 16'(v), 16'h3);
    evt_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    evt_pin[0] = 1'b0;
    repeat (3) @(negedge clk);
    ticks(1);
    rd(A_LO0, v); check("R5 edges between ticks ignored", 16'(v), 16'h3);
  endtask

  task automatic t_wrap16;
    logic [7:0] v;
    wr(A_CFG, 8'h00); wr(A_LO0, 8'hFE); wr(A_HI0, 8'hFF); wr(A_CTL, 8'h10);
    ticks(1);
    check("R6 no flag before wrap", 16'(ovf_flag), 16'h0);
    ticks(1);
    check("R6 flag on wrap", 16'(ovf_flag), 16'h1);
    rd(A_HI0, v); check("R6 wrapped to zero", 16'(v), 16'h0);
    @(negedge clk); irq_ack = 2'b01;
    @(negedge clk); irq_ack = 2'b00;
    check("R7 ack clears", 16'(ovf_flag), 16'h0);
    wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
    @(negedge clk); tick = 1'b1; irq_ack = 2'b01;
    @(negedge clk); tick = 1'b0; irq_ack = 2'b00;
    check("R7 wrap beats ack", 16'(ovf_flag), 16'h1);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_write_prio;
    logic [7:0] v;
    wr(A_CTL, 8'h10); wr(A_LO0, 8'h20); wr(A_HI0, 8'h30);
    @(negedge clk);
    tick = 1'b1; bus_addr = A_LO0; bus_wdata = 8'h55; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(A_LO0, v); check("R8 write beats increment", 16'(v), 16'h55);
    rd(A_HI0, v); check("R8 high untouched", 16'(v), 16'h30);
    wr(A_LO0, 8'hFF);
    @(negedge clk);
    tick = 1'b1; bus_addr = A_HI0; bus_wdata = 8'h40; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(A_LO0, v); check("R8 high write cancels low step", 16'(v), 16'hFF);
    rd(A_HI0, v); check("R8 high written", 16'(v), 16'h40);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_split_lo;
    logic [7:0] v;
    wr(A_CFG, 8'h01); wr(A_LO0, 8'hFE); wr(A_HI0, 8'h07); wr(A_CTL, 8'h10);
    ticks(2);
    rd(A_LO0, v); check("R9 low byte wraps", 16'(v), 16'h00);
    rd(A_HI0, v); check("R9 high byte unaffected", 16'(v), 16'h07);
    check("R9 flag 0 only", 16'(ovf_flag), 16'h1);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_split_hi;
    logic [7:0] v;
    wr(A_CFG, 8'h05); wr(A_CTL, 8'h40); wr(A_LO0, 8'h33); wr(A_HI0, 8'hFF);
    gate_pin[0] = 1'b0;
    ticks(1);
    check("R10 high wrap sets flag 1", 16'(ovf_flag), 16'h2);
    rd(A_HI0, v); check("R10 high wrapped", 16'(v), 16'h00);
    rd(A_LO0, v); check("R10 low idle without run 0", 16'(v), 16'h33);
    ticks(3);
    rd(A_HI0, v); check("R10 high ignores gate", 16'(v), 16'h03);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_unit1_borrowed;
    logic [7:0] v;
    wr(A_CFG, 8'h01); wr(A_CTL, 8'h00);
    wr(A_LO1, 8'hFF); wr(A_HI1, 8'hFF); wr(A_HI0, 8'h09);
    ticks(1);
    rd(A_LO1, v); check("R12 unit 1 counts without run 1", 16'(v), 16'h00);
    rd(A_HI1, v); check("R12 unit 1 wrapped", 16'(v), 16'h00);
    check("R12 no flag from unit 1", 16'(ovf_flag), 16'h0);
    rd(A_HI0, v); check("R10 high idle without run 1", 16'(v), 16'h09);
  endtask

  task automatic t_unit1_freeze;
    logic [7:0] v;
    wr(A_CFG, 8'h10); wr(A_CTL, 8'h40); wr(A_LO1, 8'h05); wr(A_HI1, 8'h00);
    ticks(4);
    rd(A_LO1, v); check("R11 frozen in split", 16'(v), 16'h05);
    wr(A_CFG, 8'h00);
    ticks(2);
    rd(A_LO1, v); check("R3 unit 1 resumes", 16'(v), 16'h07);
    wr(A_CTL, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_timer16();
    t_gate();
    t_event();
    t_wrap16();
    t_write_prio();
    t_split_lo();
    t_split_hi();
    t_unit1_borrowed();
    t_unit1_freeze();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule